// File: doc/BRIEF.md
# Three-Wire Register Port Slave

This block is the slave end of a three-wire serial control port. It has a serial clock, an active-low select and one data line, which is split here into an input, an output and an output enable for the pad. Through this port an external controller reads and writes a bank of 32 byte-wide configuration registers. The current contents of the bank are presented in parallel to the rest of the chip.

Each transfer opens with an instruction byte. The instruction gives the direction, the number of data bytes (one to four) and the first register address. The data bytes follow, and the block advances the address by one after each byte, wrapping from 31 back to 0. Writes land in the bank on the eighth rising clock edge of each data byte. Read bits are launched on falling edges so that the controller can sample them on rising edges. A configuration bit in register 0 switches the bit order of the whole transfer between most-significant-first and least-significant-first.

Top module: `cfg_serial_slave`

## Requirements
- R1: The instruction byte is taken from the first eight rising clock edges after the select goes low. Its bit 7 is the direction (1 = read, 0 = write), bits 6:5 give the data byte count minus one (00 = 1 byte, 11 = 4 bytes), and bits 4:0 give the start address. The data phase begins on the next bit.
- R2: In a write, the addressed register holds the new byte directly after the eighth rising edge of that data byte, before the next byte starts.
- R3: The register address rises by one after each data byte, and address 31 is followed by address 0. This holds for both reads and writes.
- R4: Registers change only at the end of a complete write data byte. Bytes sent after the encoded count has been reached leave every register unchanged.
- R5: In a read, `sdio_oe` is 1 only during the data bytes while the select is low. Read bits change on falling edges, and `sdio_oe` drops to 0 as soon as the select goes high.
- R6: Bit 6 of register 0 selects the bit order (1 = least-significant bit first, 0 = most-significant bit first). The same order applies to the instruction and to the data bytes. A new value takes effect from the next transfer on, not within the transfer that writes it.
- R7: If the select goes high partway through a byte, that partial byte is dropped and no register changes. The next transfer starts again with an instruction byte.
- R8: After reset, all registers read 0, `sdio_oe` is 0, and the bit order is most-significant-first.
- R9: After the last counted data byte of a read, the line is released (`sdio_oe` = 0) even while the select stays low and the clock keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; input sampled on rising edge, read data launched on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low transfer select |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Read data bit to the pad |
| sdio_oe | output | 1 | Pad output enable for read data |
| cfg_q | output | 256 | All 32 registers, register n at bits 8n+7:8n |

## Verification
Several properties are checked on every rising clock edge:
- the output enable is asserted only inside the data phase of a read;
- the address steps by one after each data byte;
- the register bank holds steady unless a completed write byte is present;
- a completed instruction always opens the data phase;
- once the count is used up, the block stays finished.

Other behaviour can only be shown by the bench's scenarios, which compare against a byte-level model:
- decoding of the byte count;
- the exact values that are written and read back;
- address wrap-around across register 0;
- a bit-order change taking effect only from the next transfer;
- partial bytes being discarded when the select is aborted.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
   typedef enum logic [1:0] {
      PH_INSTR = 2'd0,
      PH_DATA  = 2'd1,
      PH_DONE  = 2'd2
   } phase_e;
endpackage

// File: rtl/cfg_shift_ctrl.sv
module cfg_shift_ctrl
   import cfg_serial_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int CNT_W  = 2,
   parameter int BYTE_W = 8,
   localparam int CW    = $clog2(BYTE_W)
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              sdi,
   input  logic              order_cfg,
   output phase_e            phase_q,
   output logic              rd_q,
   output logic              lsb_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CW-1:0]     cnt_q,
   output logic              byte_end,
   output logic              wr_en,
   output logic [BYTE_W-1:0] wr_data
);
   logic [BYTE_W-2:0] sh_q;
   logic [CNT_W-1:0]  left_q;
   logic [BYTE_W-1:0] arrived;
   logic [BYTE_W-1:0] flipped;
   logic [BYTE_W-1:0] ordered;

   assign arrived = {sh_q, sdi};

   for (genvar b = 0; b < BYTE_W; b++) begin : g_flip
      assign flipped[b] = arrived[BYTE_W-1-b];
   end

   assign ordered  = lsb_q ? flipped : arrived;
   assign byte_end = (cnt_q == CW'(BYTE_W-1)) && (phase_q != PH_DONE);
   assign wr_en    = byte_end && (phase_q == PH_DATA) && !rd_q;
   assign wr_data  = ordered;

   always_ff @(posedge sclk or posedge sel_n or negedge rst_n) begin
      if (!rst_n || sel_n) begin
         phase_q <= PH_INSTR;
         rd_q    <= 1'b0;
         lsb_q   <= 1'b0;
         addr_q  <= '0;
         cnt_q   <= '0;
         left_q  <= '0;
         sh_q    <= '0;
      end else if (phase_q != PH_DONE) begin
         sh_q <= arrived[BYTE_W-2:0];
         if (phase_q == PH_INSTR && cnt_q == '0) begin
            lsb_q <= order_cfg;
         end
         if (byte_end) begin
            cnt_q <= '0;
            if (phase_q == PH_INSTR) begin
               rd_q    <= ordered[BYTE_W-1];
               left_q  <= ordered[BYTE_W-2 -: CNT_W];
               addr_q  <= ordered[ADDR_W-1:0];
               phase_q <= PH_DATA;
            end else begin
               addr_q <= addr_q + 1'b1;
               if (left_q == '0) begin
                  phase_q <= PH_DONE;
               end else begin
                  left_q <= left_q - 1'b1;
               end
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
   parameter int ADDR_W = 5,
   parameter int BYTE_W = 8,
   localparam int NUM_REGS = 1 << ADDR_W
) (
   input  logic                       sclk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [BYTE_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [BYTE_W-1:0]          rd_byte,
   output logic [NUM_REGS*BYTE_W-1:0] cfg_q
);
   logic [BYTE_W-1:0] regs [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge sclk or negedge rst_n) begin
         if (!rst_n) begin
            regs[i] <= '0;
         end else if (wr_en && wr_addr == ADDR_W'(i)) begin
            regs[i] <= wr_data;
         end
      end
      assign cfg_q[i*BYTE_W +: BYTE_W] = regs[i];
   end

   assign rd_byte = regs[rd_addr];
endmodule

// File: rtl/cfg_read_drv.sv
module cfg_read_drv
   import cfg_serial_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int CW    = $clog2(BYTE_W)
) (
   input  logic              sclk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  phase_e            phase,
   input  logic              rd,
   input  logic              lsb,
   input  logic [CW-1:0]     cnt,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              sdio_o,
   output logic              sdio_oe
);
   logic          drive_q;
   logic [CW-1:0] idx;

   assign idx = lsb ? cnt : (CW'(BYTE_W-1) - cnt);

   always_ff @(negedge sclk or posedge sel_n or negedge rst_n) begin
      if (!rst_n || sel_n) begin
         drive_q <= 1'b0;
         sdio_o  <= 1'b0;
      end else begin
         drive_q <= rd && (phase == PH_DATA);
         sdio_o  <= rd_byte[idx];
      end
   end

   assign sdio_oe = drive_q & ~sel_n;
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
   import cfg_serial_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int CNT_W     = 2,
   parameter int BYTE_W    = 8,
   parameter int ORDER_REG = 0,
   parameter int ORDER_BIT = 6,
   localparam int NUM_REGS = 1 << ADDR_W,
   localparam int CW       = $clog2(BYTE_W)
) (
   input  logic                       sclk,
   input  logic                       rst_n,
   input  logic                       sel_n,
   input  logic                       sdio_i,
   output logic                       sdio_o,
   output logic                       sdio_oe,
   output logic [NUM_REGS*BYTE_W-1:0] cfg_q
);
   if (BYTE_W != 1 + CNT_W + ADDR_W) begin : g_bad_layout
      $error("instruction fields do not fill one byte");
   end
   if (ORDER_REG >= NUM_REGS || ORDER_BIT >= BYTE_W) begin : g_bad_order
      $error("bit-order control lies outside the register bank");
   end

   phase_e            phase_q;
   logic              rd_q;
   logic              lsb_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CW-1:0]     cnt_q;
   logic              byte_end;
   logic              wr_en;
   logic [BYTE_W-1:0] wr_data;
   logic [BYTE_W-1:0] rd_byte;

   cfg_shift_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) ctrl_i (
      .sclk(sclk), .rst_n(rst_n), .sel_n(sel_n), .sdi(sdio_i),
      .order_cfg(cfg_q[ORDER_REG*BYTE_W + ORDER_BIT]),
      .phase_q(phase_q), .rd_q(rd_q), .lsb_q(lsb_q), .addr_q(addr_q),
      .cnt_q(cnt_q), .byte_end(byte_end), .wr_en(wr_en), .wr_data(wr_data)
   );

   cfg_reg_bank #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) bank_i (
      .sclk(sclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr_q),
      .wr_data(wr_data), .rd_addr(addr_q), .rd_byte(rd_byte), .cfg_q(cfg_q)
   );

   cfg_read_drv #(.BYTE_W(BYTE_W)) drv_i (
      .sclk(sclk), .rst_n(rst_n), .sel_n(sel_n), .phase(phase_q),
      .rd(rd_q), .lsb(lsb_q), .cnt(cnt_q), .rd_byte(rd_byte),
      .sdio_o(sdio_o), .sdio_oe(sdio_oe)
   );
endmodule

// File: rtl/cfg_serial_slave_chk.sv
module cfg_serial_slave_chk
   import cfg_serial_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int CFG_W   = 256
) (
   input logic              sclk,
   input logic              rst_n,
   input logic              sel_n,
   input logic              sdio_oe,
   input logic [CFG_W-1:0]  cfg_q,
   input phase_e            phase_q,
   input logic              rd_q,
   input logic [ADDR_W-1:0] addr_q,
   input logic              byte_end,
   input logic              wr_en
);
   assert_instr_opens_data_R1: assert property (@(posedge sclk) disable iff (!rst_n || sel_n)
      (phase_q == PH_INSTR && byte_end) |=> (phase_q == PH_DATA));

   assert_addr_step_R3: assert property (@(posedge sclk) disable iff (!rst_n || sel_n)
      (phase_q == PH_DATA && byte_end) |=> (addr_q == $past(addr_q) + 1'b1));

   assert_bank_hold_R4: assert property (@(posedge sclk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_q));

   assert_oe_read_only_R5: assert property (@(posedge sclk) disable iff (!rst_n)
      sdio_oe |-> (rd_q && phase_q == PH_DATA && !sel_n));

   assert_done_sticky_R9: assert property (@(posedge sclk) disable iff (!rst_n || sel_n)
      (phase_q == PH_DONE) |=> (phase_q == PH_DONE));

   always_comb begin
      if (sel_n) begin
         assert_release_on_deselect_R5: assert (!sdio_oe);
      end
   end
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(.ADDR_W(ADDR_W), .CFG_W(NUM_REGS*BYTE_W)) chk_i (
   .sclk(sclk), .rst_n(rst_n), .sel_n(sel_n), .sdio_oe(sdio_oe), .cfg_q(cfg_q),
   .phase_q(phase_q), .rd_q(rd_q), .addr_q(addr_q), .byte_end(byte_end), .wr_en(wr_en)
);

// File: tb/cfg_serial_slave_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_slave_tb_top;
   logic         sclk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sel_n = 1'b1;
   logic         tb_bit = 1'b0;
   logic         sdio_o;
   logic         sdio_oe;
   logic [255:0] cfg_q;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   logic [7:0]  mem [32];
   logic        lsb_mode = 1'b0;
   logic [7:0]  exp_q [$];
   logic [7:0]  got_q [$];
   string       tag_q [$];

   always #2.5 sclk = ~sclk;

   cfg_serial_slave dut_i (
      .sclk(sclk), .rst_n(rst_n), .sel_n(sel_n), .sdio_i(tb_bit),
      .sdio_o(sdio_o), .sdio_oe(sdio_oe), .cfg_q(cfg_q)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // scoreboard monitor: compares read bytes in order
   initial begin
      forever begin
         @(posedge sclk);
         while (got_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] g;
            logic [7:0] e;
            string t;
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {24'h0, g}, {24'h0, e});
         end
      end
   end

   initial begin
      repeat (100000) @(posedge sclk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   task automatic send_byte(input logic [7:0] b, input bit first);
      for (int i = 0; i < 8; i++) begin
         @(negedge sclk);
         if (first && i == 0) sel_n = 1'b0;
         tb_bit = lsb_mode ? b[i] : b[7-i];
      end
   endtask

   task automatic end_xfer();
      @(negedge sclk);
      sel_n = 1'b1;
      #1;
      check("R5 release on deselect", {31'h0, sdio_oe}, 32'h0);
   endtask

   function automatic logic [7:0] reg_of(input int a);
      return cfg_q[a*8 +: 8];
   endfunction

   task automatic wr_xfer(input int a, input logic [7:0] d [], input int extra);
      int n;
      n = d.size();
      send_byte({1'b0, 2'(n-1), 5'(a)}, 1'b1);
      for (int k = 0; k < n; k++) begin
         int ra;
         ra = (a + k) % 32;
         send_byte(d[k], 1'b0);
         @(posedge sclk);
         #1;
         mem[ra] = d[k];
         check($sformatf("R2/R3 write reg %0d", ra), {24'h0, reg_of(ra)}, {24'h0, d[k]});
      end
      for (int k = 0; k < extra; k++) send_byte(8'hFF, 1'b0);
      end_xfer();
      lsb_mode = mem[0][6];
   endtask

   task automatic rd_xfer(input int a, input int n);
      send_byte({1'b1, 2'(n-1), 5'(a)}, 1'b1);
      @(posedge sclk);
      #1;
      for (int k = 0; k < n; k++) begin
         logic [7:0] v;
         int ra;
         ra = (a + k) % 32;
         exp_q.push_back(mem[ra]);
         tag_q.push_back($sformatf("R3/R6 read reg %0d", ra));
         for (int i = 0; i < 8; i++) begin
            @(negedge sclk);
            #1;
            check("R5 oe during read data", {31'h0, sdio_oe}, 32'h1);
            if (lsb_mode) v[i] = sdio_o; else v[7-i] = sdio_o;
         end
         got_q.push_back(v);
      end
      @(negedge sclk);
      #1;
      check("R9 released after count", {31'h0, sdio_oe}, 32'h0);
      end_xfer();
   endtask

   initial begin
      for (int i = 0; i < 32; i++) mem[i] = 8'h00;
      repeat (3) @(negedge sclk);
      #1;
      check("R8 reset reg bank", {31'h0, (cfg_q == '0)}, 32'h1);
      check("R8 reset oe", {31'h0, sdio_oe}, 32'h0);
      rst_n = 1'b1;
      repeat (2) @(negedge sclk);

      // R1 R2: single byte write, MSB first
      wr_xfer(5, '{8'hA5}, 0);
      // R3 wrap and R6: write reg 0 bit 6 mid-transfer; bytes after stay MSB-first
      wr_xfer(30, '{8'h11, 8'h22, 8'h40, 8'h5A}, 0);
      check("R6 mode bit set", {31'h0, reg_of(0)[6]}, 32'h1);
      // R6: read now LSB-first
      rd_xfer(30, 2);
      // R4: bytes past the count are ignored
      wr_xfer(7, '{8'h3C}, 2);
      check("R4 reg 8 untouched by extra bytes", {24'h0, reg_of(8)}, 32'h0);
      // R7: abort inside a data byte
      send_byte({1'b0, 2'b00, 5'd9}, 1'b1);
      for (int i = 0; i < 4; i++) begin
         @(negedge sclk);
         tb_bit = 1'b1;
      end
      end_xfer();
      check("R7 partial data byte dropped", {24'h0, reg_of(9)}, 32'h0);
      // R7: abort inside instruction, then a normal transfer
      for (int i = 0; i < 3; i++) begin
         @(negedge sclk);
         sel_n = 1'b0;
         tb_bit = 1'b1;
      end
      end_xfer();
      wr_xfer(9, '{8'h77}, 0);
      check("R7 clean restart", {24'h0, reg_of(9)}, 32'h77);
      // R6: back to MSB-first (this instruction is still LSB-first)
      wr_xfer(0, '{8'h00}, 0);
      rd_xfer(5, 1);
      // R3: read across the wrap
      rd_xfer(31, 3);
      // R1: four byte write then read back
      wr_xfer(12, '{8'hC3, 8'h96, 8'h0F, 8'hE1}, 0);
      rd_xfer(12, 4);
      // R5: abort a read partway through a byte
      send_byte({1'b1, 2'b01, 5'd12}, 1'b1);
      repeat (4) @(negedge sclk);
      #1;
      check("R5 oe mid read", {31'h0, sdio_oe}, 32'h1);
      end_xfer();
      check("R1 regs unchanged by reads", {24'h0, reg_of(13)}, 32'h96);
      repeat (20) @(negedge sclk);
      check("scoreboard drained", exp_q.size(), 32'h0);
      summary();
   end
endmodule